// File: doc/BRIEF.md
# Mailbox Channel Router with Host Interrupt

This block connects a host CPU to a small set of numbered child channels through a word-wide register window. Host writes into the outbound window name their target channel in the low four bits of the data word. A free child receives the word straight away as a one-cycle request strobe. A busy child causes the word to be counted into an outbound queue instead. A write to a full outbound queue, or to a channel number the block does not have, is dropped and sets a sticky error flag.

In the other direction, children raise a response-valid flag together with a word. The block takes these words one per cycle into an inbound queue. On each cycle it serves the lowest-numbered channel that has a word, for as long as the queue has room. The host drains the queue through a pop window or inspects the oldest word through a peek register. A level interrupt is raised while the inbound queue holds data and the host has enabled that interrupt.

The bus carries 32-bit accesses only. The block decodes the low eight address bits. Read data appears one cycle after the read request.

Top module: `mbox_router`

## Requirements
- R1: A read at offsets 0x80, 0x84, 0x88 or 0x8C removes and returns the oldest inbound word. A read at 0x90 returns that word without removing it. Reads at 0x94, at unaligned offsets and at unsupported offsets return zero. Every read returns its data with rd_valid one cycle after the request.
- R2: A status read returns bit 31 = queue full, bit 30 = queue empty and bits 7:0 = queue level, with all other bits zero. Offset 0x98 reports the inbound queue and offset 0xB8 reports the outbound queue.
- R3: A pop or peek of an empty inbound queue returns the sentinel 0x0000000F and changes no state.
- R4: A write at 0x9C loads the interrupt enable from data bit 0. No other bit of the written word reaches the config word.
- R5: A config read (0x9C) returns bit 0 = enable, bit 4 = inbound not empty and bit 9 = error flag, with all other bits zero. The irq output equals bit 4 AND bit 0.
- R6: For a write at 0xA0 to 0xAC whose data bits 3:0 name a channel below the channel count, when that channel is not busy and the outbound queue is not full, the request strobe for that channel is high during the write cycle and the request word carries the full data.
- R7: The same write to a busy channel raises no strobe and adds one to the outbound queue level.
- R8: An outbound write is dropped when the outbound queue is full or when the channel number is at or above the channel count. A dropped write raises no strobe and sets the config error flag. Any config write clears that flag.
- R9: Inbound collection takes at most one word per cycle and always serves the lowest-numbered channel whose response is valid. The block acknowledges the taken word with a one-cycle ready to that channel only.
- R10: While the inbound queue is full, no channel receives ready. Collection resumes once the host pops a word.
- R11: A response word offered by a channel never equals the sentinel.
- R12: Writes at 0x94 and at unsupported offsets change no state and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset (low 8 address bits) |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt: inbound data waiting and enabled |
| ch_rsp_valid | input | N_CH | Per-channel response available |
| ch_rsp_data | input | N_CH*32 | Per-channel response words, channel i at bits i*32 +: 32 |
| ch_rsp_ready | output | N_CH | Per-channel response taken this cycle |
| ch_busy | input | N_CH | Per-channel busy level |
| ch_req_valid | output | N_CH | Per-channel request strobe |
| ch_req_data | output | 32 | Request word shared by all channels |

## Verification
Dispatch is tried with a free channel, a busy channel, a channel number beyond the count and a full outbound queue. These cases separate direct delivery, queueing and the two ways a write is dropped. Collection is tried with three sparse channels raised at the same time, checking both the order the words come out in and which flags remain after one cycle. This tells strict lowest-first priority apart from arrival order or batch transfer. With all channels raised against a smaller queue, the bench checks that exactly the highest channel is held back and then admitted after one pop. The config write that sets every bit except bit 0 shows that only the enable is writable.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int WORD_W = 32;

    localparam logic [7:0] OFF_PEEK     = 8'h90;
    localparam logic [7:0] OFF_SENDER   = 8'h94;
    localparam logic [7:0] OFF_IN_STAT  = 8'h98;
    localparam logic [7:0] OFF_CFG      = 8'h9C;
    localparam logic [7:0] OFF_OUT_STAT = 8'hB8;
    localparam logic [3:0] WIN_POP      = 4'h8;
    localparam logic [3:0] WIN_OUT      = 4'hA;

    localparam logic [WORD_W-1:0] SENTINEL = 32'h0000_000F;

    function automatic logic [WORD_W-1:0] status_word(input logic full,
                                                      input logic empty,
                                                      input logic [7:0] level);
        return {full, empty, 22'd0, level};
    endfunction

    function automatic logic [WORD_W-1:0] config_word(input logic en,
                                                      input logic pend,
                                                      input logic err);
        return {22'd0, err, 4'd0, pend, 3'd0, en};
    endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);

    assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/mbox_gather.sv
module mbox_gather #(
    parameter int          N_CH     = 9,
    parameter int          W        = 32,
    parameter logic [W-1:0] SENT    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   rsp_valid,
    input  logic [N_CH*W-1:0] rsp_data,
    input  logic              space,
    output logic [N_CH-1:0]   rsp_ready,
    output logic              take,
    output logic [W-1:0]      take_data
);
    always_comb begin
        rsp_ready = '0;
        take      = 1'b0;
        take_data = '0;
        for (int i = N_CH-1; i >= 0; i--) begin
            if (rsp_valid[i] && space) begin
                rsp_ready    = '0;
                rsp_ready[i] = 1'b1;
                take         = 1'b1;
                take_data    = rsp_data[i*W +: W];
            end
        end
    end

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_ready));
    assert_grant_to_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready & ~rsp_valid) == '0);
    assert_no_grant_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !space |-> (rsp_ready == '0));
    assert_no_sentinel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (take_data != SENT));
endmodule

// File: rtl/mbox_router.sv
module mbox_router
    import mbox_pkg::*;
#(
    parameter int N_CH     = 9,
    parameter int IN_DEPTH = 8,
    parameter int OB_DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [7:0]               bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic                     rd_valid,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     irq,
    input  logic [N_CH-1:0]          ch_rsp_valid,
    input  logic [N_CH*WORD_W-1:0]   ch_rsp_data,
    output logic [N_CH-1:0]          ch_rsp_ready,
    input  logic [N_CH-1:0]          ch_busy,
    output logic [N_CH-1:0]          ch_req_valid,
    output logic [WORD_W-1:0]        ch_req_data
);
    localparam int IN_CNT_W = $clog2(IN_DEPTH+1);
    localparam int OB_CNT_W = $clog2(OB_DEPTH+1);

    typedef struct packed {
        logic [WORD_W-1:0]   rdata;
        logic                rvalid;
        logic                irq_en;
        logic                err;
        logic [OB_CNT_W-1:0] ob_cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic [WORD_W-1:0]   in_head, take_data;
    logic [IN_CNT_W-1:0] in_cnt;
    logic                in_full, in_empty, take, in_pop;
    logic                rd_req, wr_req, aligned, pop_hit, out_hit, cfg_wr;
    logic                ch_ok, busy_sel, drop, queue_it, direct;
    logic                ob_full;
    logic [3:0]          ch;
    logic [WORD_W-1:0]   rd_mux;

    mbox_fifo #(.DEPTH(IN_DEPTH), .W(WORD_W)) u_inq (
        .clk(clk), .rst_n(rst_n),
        .push(take), .push_data(take_data), .pop(in_pop),
        .head(in_head), .count(in_cnt), .full(in_full), .empty(in_empty)
    );

    mbox_gather #(.N_CH(N_CH), .W(WORD_W), .SENT(SENTINEL)) u_gather (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(ch_rsp_valid), .rsp_data(ch_rsp_data), .space(!in_full),
        .rsp_ready(ch_rsp_ready), .take(take), .take_data(take_data)
    );

    // Access decode
    always_comb begin
        rd_req  = bus_valid && !bus_write;
        wr_req  = bus_valid && bus_write;
        aligned = (bus_addr[1:0] == 2'b00);
        pop_hit = rd_req && aligned && (bus_addr[7:4] == WIN_POP);
        in_pop  = pop_hit && !in_empty;
        out_hit = wr_req && aligned && (bus_addr[7:4] == WIN_OUT);
        cfg_wr  = wr_req && (bus_addr == OFF_CFG);
        ob_full = (r_q.ob_cnt == OB_CNT_W'(OB_DEPTH));
    end

    // Outbound channel steering
    always_comb begin
        ch       = bus_wdata[3:0];
        ch_ok    = (int'(ch) < N_CH);
        busy_sel = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (ch == 4'(i)) busy_sel = ch_busy[i];
        end
        drop     = out_hit && (ob_full || !ch_ok);
        queue_it = out_hit && !drop && busy_sel;
        direct   = out_hit && !drop && !busy_sel;
        ch_req_valid = '0;
        for (int i = 0; i < N_CH; i++) begin
            ch_req_valid[i] = direct && (ch == 4'(i));
        end
        ch_req_data = bus_wdata;
    end

    // Read data select
    always_comb begin
        rd_mux = '0;
        if (pop_hit) begin
            rd_mux = in_empty ? SENTINEL : in_head;
        end else begin
            case (bus_addr)
                OFF_PEEK:     rd_mux = in_empty ? SENTINEL : in_head;
                OFF_IN_STAT:  rd_mux = status_word(in_full, in_empty, 8'(in_cnt));
                OFF_CFG:      rd_mux = config_word(r_q.irq_en, !in_empty, r_q.err);
                OFF_OUT_STAT: rd_mux = status_word(ob_full, r_q.ob_cnt == '0, 8'(r_q.ob_cnt));
                default:      rd_mux = '0;
            endcase
        end
    end

    // Next-state
    always_comb begin
        r_d        = r_q;
        r_d.rvalid = rd_req;
        r_d.rdata  = rd_req ? rd_mux : '0;
        if (cfg_wr) begin
            r_d.irq_en = bus_wdata[0];
            r_d.err    = 1'b0;
        end else if (drop) begin
            r_d.err    = 1'b1;
        end
        r_d.ob_cnt = r_q.ob_cnt + OB_CNT_W'(queue_it);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.rvalid;
    assign rd_data  = r_q.rdata;
    assign irq      = r_q.irq_en && !in_empty;

    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid);
    assert_empty_pop_sentinel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_hit && in_empty) |=> (rd_data == SENTINEL));
    assert_req_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_req_valid));
    assert_req_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req_valid & ch_busy) == '0);
    assert_ob_never_over_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ob_cnt <= OB_CNT_W'(OB_DEPTH));
    assert_drop_sets_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> r_q.err);
    assert_cfg_clears_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !r_q.err);
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !bus_wdata[0]) |=> !irq);
endmodule

// File: tb/mbox_router_tb.sv
module mbox_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH = 9;
    localparam logic [31:0] SENT = 32'h0000_000F;
    localparam logic [31:0] ST_EMPTY = 32'h4000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic rd_valid, irq;
    logic [31:0] rd_data, ch_req_data;
    logic [N_CH-1:0] rsp_v = '0;
    logic [N_CH-1:0][31:0] rsp_d = '0;
    logic [N_CH*32-1:0] rsp_flat;
    logic [N_CH-1:0] ch_rsp_ready, ch_busy = '0, ch_req_valid;

    int checks = 0, errors = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb for (int i = 0; i < N_CH; i++) rsp_flat[i*32 +: 32] = rsp_d[i];

    mbox_router #(.N_CH(N_CH), .IN_DEPTH(8), .OB_DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq),
        .ch_rsp_valid(rsp_v), .ch_rsp_data(rsp_flat), .ch_rsp_ready(ch_rsp_ready),
        .ch_busy(ch_busy), .ch_req_valid(ch_req_valid), .ch_req_data(ch_req_data)
    );

    // Child model: a taken response is withdrawn
    always @(posedge clk)
        for (int i = 0; i < N_CH; i++) if (ch_rsp_ready[i]) rsp_v[i] <= 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each returned read
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R1 unexpected read data", rd_data, 32'h0);
            else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d,
                          input logic [N_CH-1:0] exp_req, input string t);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        check(ch_req_valid === exp_req, t, 32'(ch_req_valid), 32'(exp_req));
        if (exp_req != '0) check(ch_req_data === d, t, ch_req_data, d);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // Reset state
        check(irq === 1'b0, "R5 reset irq", 32'(irq), 32'h0);
        bus_rd(8'h98, ST_EMPTY, "R2 reset inbound status");
        bus_rd(8'hB8, ST_EMPTY, "R2 reset outbound status");
        bus_rd(8'h9C, 32'h0, "R5 reset config");
        bus_rd(8'h80, SENT, "R3 pop empty");
        bus_rd(8'h90, SENT, "R3 peek empty");
        bus_rd(8'h94, 32'h0, "R1 sender reads zero");
        bus_rd(8'h40, 32'h0, "R1 unsupported reads zero");

        // Direct dispatch
        bus_wr(8'hA4, 32'h1234_5673, 9'h008, "R6 direct to ch3");
        bus_rd(8'hB8, ST_EMPTY, "R6 direct leaves outbound empty");

        // Busy channel queues
        ch_busy[5] = 1'b1;
        bus_wr(8'hA0, 32'hCAFE_0005, 9'h000, "R7 busy ch5 no strobe");
        bus_rd(8'hB8, 32'h0000_0001, "R7 outbound level 1");

        // Invalid channel dropped
        bus_wr(8'hA8, 32'h0000_000B, 9'h000, "R8 invalid channel no strobe");
        bus_rd(8'h9C, 32'h0000_0200, "R8 error flag set");
        bus_rd(8'hB8, 32'h0000_0001, "R8 invalid keeps outbound level");
        bus_wr(8'h9C, 32'h0000_0001, 9'h000, "R8 config write");
        bus_rd(8'h9C, 32'h0000_0001, "R8 config write clears flag");

        // Fill outbound, then overflow
        for (int k = 0; k < 7; k++) bus_wr(8'hAC, 32'h0000_0005, 9'h000, "R7 fill outbound");
        bus_rd(8'hB8, 32'h8000_0008, "R2 outbound full");
        bus_wr(8'hA0, 32'h0000_0002, 9'h000, "R8 full outbound drops free channel");
        bus_rd(8'h9C, 32'h0000_0201, "R8 overflow flag");
        bus_wr(8'h9C, 32'h0000_0001, 9'h000, "R8 clear");

        // Ignored writes
        bus_wr(8'h94, 32'hFFFF_FFFF, 9'h000, "R12 sender write");
        bus_wr(8'h40, 32'h0000_0000, 9'h000, "R12 unsupported write");
        bus_rd(8'h9C, 32'h0000_0001, "R12 config unchanged");
        bus_rd(8'h98, ST_EMPTY, "R12 inbound unchanged");

        // Ordered collection, one per cycle
        rsp_d[7] = 32'hBBBB_0070; rsp_d[2] = 32'hAAAA_0020; rsp_d[0] = 32'hCCCC_0000;
        rsp_v = 9'b0_1000_0101;
        @(negedge clk);
        check(rsp_v === 9'b0_1000_0100, "R9 lowest channel taken first", 32'(rsp_v), 32'h84);
        @(negedge clk);
        check(rsp_v === 9'b0_1000_0000, "R9 second transfer ch2", 32'(rsp_v), 32'h80);
        idle(3);
        check(irq === 1'b1, "R5 irq with data and enable", 32'(irq), 32'h1);
        bus_rd(8'h98, 32'h0000_0003, "R2 inbound level 3");
        bus_rd(8'h90, 32'hCCCC_0000, "R1 peek head");
        bus_rd(8'h84, 32'hCCCC_0000, "R9 pop order 1");
        bus_rd(8'h88, 32'hAAAA_0020, "R9 pop order 2");
        bus_rd(8'h83, 32'h0, "R1 unaligned pop reads zero");
        bus_rd(8'h8C, 32'hBBBB_0070, "R9 pop order 3");
        bus_rd(8'h98, ST_EMPTY, "R2 inbound empty again");
        check(irq === 1'b0, "R5 irq low when empty", 32'(irq), 32'h0);

        // Inbound full back-pressure
        for (int i = 0; i < N_CH; i++) rsp_d[i] = 32'h100 + 32'(i) * 32'h10;
        rsp_v = '1;
        idle(12);
        check(rsp_v === 9'h100, "R10 last channel held back", 32'(rsp_v), 32'h100);
        check(ch_rsp_ready === '0, "R10 no ready while full", 32'(ch_rsp_ready), 32'h0);
        bus_rd(8'h98, 32'h8000_0008, "R2 inbound full");
        bus_wr(8'h9C, 32'hFFFF_FFFE, 9'h000, "R4 config write all but bit0");
        check(irq === 1'b0, "R4 irq disabled", 32'(irq), 32'h0);
        bus_rd(8'h9C, 32'h0000_0010, "R4 only enable written");
        bus_rd(8'h80, 32'h0000_0100, "R10 pop ch0 word");
        idle(3);
        check(rsp_v === 9'h000, "R10 collection resumes", 32'(rsp_v), 32'h0);
        for (int i = 1; i < N_CH; i++)
            bus_rd(8'h80, 32'h100 + 32'(i) * 32'h10, "R9 drain in channel order");
        bus_rd(8'h80, SENT, "R3 pop after drain");
        idle(3);

        if (exp_q.size() != 0) check(1'b0, "R1 missing read data", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule